// File: doc/BRIEF.md
# PCM Code Format Converter

This block converts audio samples in both directions between the internal 14-bit two's-complement form and the code that a serial PCM port carries. On the transmit side, a 14-bit sample becomes either a 14-bit linear word or an 8-bit companded byte. On the receive side, a linear word or companded byte is expanded back to a 14-bit two's-complement sample. The two directions run side by side. Each has its own input and its own output, and both use the same mode controls.

Three control pins choose the format. `code_mode` picks companded coding (1) or linear coding (0). `code_sel` picks the variant within that mode, and it can change on any cycle. A cycle with `in_valid` high loads both results into output registers. On the next cycle the results appear, together with `out_valid`. Serial framing, filtering and analog conversion happen outside this block.

Top module: `pcm_code_converter`

## Requirements
- R1: A synchronous active-low reset drives `out_valid`, `tx_code` and `rx_sample` to zero. Reset takes priority over `in_valid`.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. Both results of that sample are on the outputs in the same cycle.
- R3: While `in_valid` is low, `tx_code` and `rx_sample` keep their values, whatever the other inputs do.
- R4: Linear mode with `code_sel`=00 (two's complement) passes `tx_sample` to `tx_code` and `rx_code` to `rx_sample` unchanged.
- R5: Linear mode with `code_sel`=01 (one's complement):
  - A negative sample is coded as the bitwise inverse of its magnitude, and -8192 is clipped to magnitude 8191, giving 14'h2000.
  - On decode, the negative-zero code 14'h3FFF gives 0.
- R6: Linear mode with `code_sel`=10 or 11 (sign-magnitude):
  - Bit 13 is the sign (1 = negative) and bits 12:0 hold the magnitude.
  - -8192 codes as 14'h3FFF.
  - 14'h2000 decodes to 0.
- R7: In companded mode the code occupies `tx_code[7:0]` and `tx_code[13:8]` is zero. `rx_code[13:8]` has no effect on `rx_sample`.
- R8: Companded mode with `code_sel`=00 encodes mu-255 law:
  - Take the magnitude and clip it to 8159.
  - Add 33 and find segment s, the highest set bit at position 5+s, with s up to 7. A sum of 8192 saturates to segment/mantissa 7'h7F.
  - The mantissa is bits s+4..s+1.
  - The 7 segment/mantissa bits are inverted. Bit 7 is 1 for a non-negative sample.
  - Reference points: +8191 gives 8'h80, 0 gives 8'hFF, -8192 gives 8'h00.
- R9: Mu-255 decoding:
  - Invert the byte. Bit 7 = 1 means negative; bits 6:4 are s and bits 3:0 are m.
  - The magnitude is ((2m+33) << s) - 33.
- R10: Companded mode with `code_sel`=10 or 11 encodes A law without even-bit inversion:
  - Start from a = floor(x/2). The magnitude is a, or -a-1 when a is negative.
  - The segment is the highest set bit at position 4+s.
  - The mantissa is the magnitude shifted right by max(s,1), bits 3:0.
  - Bit 7 is 1 for a non-negative sample.
  - Reference points: +8191 gives 8'hFF, 0 gives 8'h80, -8192 gives 8'h7F.
- R11: Companded mode with `code_sel`=01 outputs the R10 code XOR 8'h55. Reference points: 8'hAA, 8'hD5 and 8'h2A.
- R12: A-law decoding (for `code_sel`=01, first XOR with 8'h55):
  - Bit 7 = 1 means positive; bits 6:4 are s and bits 3:0 are m.
  - The magnitude is 4m+2 for s=0, and (4m+66) << (s-1) otherwise.
- R13: A change of `code_mode` or `code_sel` applies to the sample presented in the same cycle. Consecutive samples may each use a different format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe; loads both results |
| code_mode | input | 1 | 0 = linear 14-bit coding, 1 = companded 8-bit coding |
| code_sel | input | 2 | Variant select within the chosen mode |
| tx_sample | input | 14 | Two's-complement sample to encode |
| rx_code | input | 14 | Code to decode (low 8 bits in companded mode) |
| out_valid | output | 1 | High one cycle after each strobe |
| tx_code | output | 14 | Encoded output code |
| rx_sample | output | 14 | Decoded two's-complement sample |

## Verification
Both conversions are due exactly one clock after the cycle that strobes them, and `out_valid` follows the strobe by the same single cycle. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs with a behavioural model that has been advanced by one registered stage. This keeps every comparison one rising edge behind its stimulus. Cycles without a strobe are compared against the held model values, so a stray update shows up on the first cycle it happens. Fixed reference points are checked one cycle after their strobe, on a cycle with the strobe already dropped.

// File: rtl/pcm_conv_pkg.sv
// Package: shared widths, constants and format selectors for the PCM
// code converter. Assumes a 14-bit sample and an 8-bit companded code.
package pcm_conv_pkg;

    localparam int SAMPLE_W = 14;
    localparam int COMP_W   = 8;
    localparam int PAD_W    = SAMPLE_W - COMP_W;
    localparam int SEG_W    = 3;
    localparam int MANT_W   = 4;
    localparam int A_MAG_W  = SAMPLE_W - 2;
    localparam int MU_BIAS  = 33;
    localparam int MU_CLIP  = 8159;
    localparam int A_SEG0_OFS = 2;
    localparam int A_SEGN_OFS = 66;
    localparam logic [COMP_W-1:0] EVEN_MASK = 8'h55;

    typedef enum logic [1:0] {
        FMT_TWOS    = 2'd0,
        FMT_ONES    = 2'd1,
        FMT_SIGNMAG = 2'd2
    } lin_fmt_e;

    typedef enum logic [1:0] {
        LAW_MU      = 2'd0,
        LAW_A_INV   = 2'd1,
        LAW_A_PLAIN = 2'd2
    } comp_fmt_e;

    // Map the two select pins to a linear representation.
    function automatic lin_fmt_e lin_fmt(input logic [1:0] sel);
        if (sel[1])      return FMT_SIGNMAG;
        else if (sel[0]) return FMT_ONES;
        else             return FMT_TWOS;
    endfunction

    // Map the two select pins to a companding law.
    function automatic comp_fmt_e comp_fmt(input logic [1:0] sel);
        if (sel[1])      return LAW_A_PLAIN;
        else if (sel[0]) return LAW_A_INV;
        else             return LAW_MU;
    endfunction

endpackage

// File: rtl/pcm_linear_codec.sv
// Linear codec: converts a two's-complement sample to two's, one's
// complement or sign-magnitude, and converts such a code back. Purely
// combinational. Assumes the most negative input is clipped to the largest
// representable magnitude, and that negative zero decodes to 0.
module pcm_linear_codec
    import pcm_conv_pkg::*;
(
    input  lin_fmt_e              fmt,
    input  logic [SAMPLE_W-1:0]   sample_in,
    input  logic [SAMPLE_W-1:0]   code_in,
    output logic [SAMPLE_W-1:0]   code_out,
    output logic [SAMPLE_W-1:0]   sample_out
);

    localparam logic [SAMPLE_W-1:0] MAX_MAG = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic                sgn_in;
    logic [SAMPLE_W-1:0] mag_in;
    logic                sgn_code;
    logic [SAMPLE_W-1:0] sm_mag;

    assign sgn_in   = sample_in[SAMPLE_W-1];
    assign sgn_code = code_in[SAMPLE_W-1];
    assign sm_mag   = {1'b0, code_in[SAMPLE_W-2:0]};

    // Encode: clipped magnitude, then the selected representation.
    always_comb begin
        mag_in = sgn_in ? (~sample_in + 1'b1) : sample_in;
        if (mag_in[SAMPLE_W-1]) mag_in = MAX_MAG;
        case (fmt)
            FMT_ONES:    code_out = sgn_in ? ~mag_in : mag_in;
            FMT_SIGNMAG: code_out = {sgn_in, mag_in[SAMPLE_W-2:0]};
            default:     code_out = sample_in;
        endcase
    end

    // Decode: the selected representation back to two's complement.
    always_comb begin
        case (fmt)
            FMT_ONES:    sample_out = sgn_code ? (code_in + 1'b1) : code_in;
            FMT_SIGNMAG: sample_out = sgn_code ? (~sm_mag + 1'b1) : code_in;
            default:     sample_out = code_in;
        endcase
    end

endmodule

// File: rtl/pcm_mulaw_codec.sv
// Mu-255 law codec: biased segment encoder and matching expander.
// Purely combinational. Assumes a 14-bit two's-complement sample;
// the 8-bit code is sent with its segment/mantissa bits inverted.
module pcm_mulaw_codec
    import pcm_conv_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [COMP_W-1:0]   code_in,
    output logic [COMP_W-1:0]   code_out,
    output logic [SAMPLE_W-1:0] sample_out
);

    localparam int SEGS = 1 << SEG_W;
    localparam int BASE_BIT = MANT_W + 1;

    logic                    sgn;
    logic [SAMPLE_W-1:0]     mag;
    logic [SAMPLE_W-1:0]     biased;
    logic [SEG_W-1:0]        seg;
    logic [MANT_W-1:0]       mant;
    logic [COMP_W-2:0]       raw;
    logic [COMP_W-1:0]       inv;
    logic [SAMPLE_W-1:0]     expd;
    logic [SAMPLE_W-1:0]     dmag;

    assign sgn = sample_in[SAMPLE_W-1];

    // Encode: clip, bias, find segment, take mantissa, invert.
    always_comb begin
        mag = sgn ? (~sample_in + 1'b1) : sample_in;
        if (mag > SAMPLE_W'(MU_CLIP)) mag = SAMPLE_W'(MU_CLIP);
        biased = mag + SAMPLE_W'(MU_BIAS);
        seg = '0;
        for (int k = 1; k < SEGS; k++) begin
            if (biased[BASE_BIT + k]) seg = SEG_W'(k);
        end
        mant = MANT_W'(biased >> ({1'b0, seg} + 4'd1));
        raw  = biased[SAMPLE_W-1] ? {(COMP_W-1){1'b1}} : {seg, mant};
        code_out = {~sgn, ~raw};
    end

    // Decode: invert, rebuild the biased value, remove the bias, apply sign.
    always_comb begin
        inv  = ~code_in;
        expd = ({{(SAMPLE_W-MANT_W-1){1'b0}}, inv[MANT_W-1:0], 1'b0}
                + SAMPLE_W'(MU_BIAS)) << inv[COMP_W-2:MANT_W];
        dmag = expd - SAMPLE_W'(MU_BIAS);
        sample_out = inv[COMP_W-1] ? (~dmag + 1'b1) : dmag;
    end

endmodule

// File: rtl/pcm_alaw_codec.sv
// A law codec with selectable even-bit inversion. Purely combinational.
// Assumes a 14-bit two's-complement sample; the A-law magnitude is taken
// from the sample halved (floor), negative values using the inverse.
module pcm_alaw_codec
    import pcm_conv_pkg::*;
(
    input  logic                invert_even,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [COMP_W-1:0]   code_in,
    output logic [COMP_W-1:0]   code_out,
    output logic [SAMPLE_W-1:0] sample_out
);

    localparam int SEGS = 1 << SEG_W;

    logic                    pos;
    logic [A_MAG_W-1:0]      mag;
    logic [SEG_W-1:0]        seg;
    logic [SEG_W-1:0]        shift;
    logic [MANT_W-1:0]       mant;
    logic [COMP_W-1:0]       plain;
    logic [COMP_W-1:0]       pc;
    logic [SEG_W-1:0]        dseg;
    logic [SAMPLE_W-1:0]     base;
    logic [SAMPLE_W-1:0]     dmag;

    assign pos = ~sample_in[SAMPLE_W-1];

    // Encode: halved magnitude, segment search, mantissa, optional mask.
    always_comb begin
        mag = pos ? sample_in[SAMPLE_W-2:1] : ~sample_in[SAMPLE_W-2:1];
        seg = '0;
        for (int k = 1; k < SEGS; k++) begin
            if (mag[MANT_W + k]) seg = SEG_W'(k);
        end
        shift = (seg == '0) ? SEG_W'(1) : seg;
        mant  = MANT_W'(mag >> shift);
        plain = {pos, seg, mant};
        code_out = invert_even ? (plain ^ EVEN_MASK) : plain;
    end

    // Decode: remove mask, rebuild magnitude from segment, apply sign.
    always_comb begin
        pc   = invert_even ? (code_in ^ EVEN_MASK) : code_in;
        dseg = pc[COMP_W-2:MANT_W];
        base = {{(SAMPLE_W-MANT_W-2){1'b0}}, pc[MANT_W-1:0], 2'b00};
        if (dseg == '0) dmag = base + SAMPLE_W'(A_SEG0_OFS);
        else            dmag = (base + SAMPLE_W'(A_SEGN_OFS)) << (dseg - 1'b1);
        sample_out = pc[COMP_W-1] ? dmag : (~dmag + 1'b1);
    end

endmodule

// File: rtl/pcm_code_converter.sv
// Top: selects one of six code formats from the mode pins, runs the
// encode and decode paths side by side and registers both results on
// each strobe. Assumes the mode pins are valid in the strobe cycle.
module pcm_code_converter
    import pcm_conv_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                code_mode,
    input  logic [1:0]          code_sel,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic [SAMPLE_W-1:0] rx_code,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] tx_code,
    output logic [SAMPLE_W-1:0] rx_sample
);

    lin_fmt_e            lfmt;
    comp_fmt_e           cfmt;
    logic [SAMPLE_W-1:0] lin_code, lin_smp;
    logic [COMP_W-1:0]   mu_code, a_code;
    logic [SAMPLE_W-1:0] mu_smp, a_smp;
    logic [SAMPLE_W-1:0] enc_nx, dec_nx;

    assign lfmt = lin_fmt(code_sel);
    assign cfmt = comp_fmt(code_sel);

    pcm_linear_codec u_lin (
        .fmt        (lfmt),
        .sample_in  (tx_sample),
        .code_in    (rx_code),
        .code_out   (lin_code),
        .sample_out (lin_smp)
    );

    pcm_mulaw_codec u_mu (
        .sample_in  (tx_sample),
        .code_in    (rx_code[COMP_W-1:0]),
        .code_out   (mu_code),
        .sample_out (mu_smp)
    );

    pcm_alaw_codec u_a (
        .invert_even (cfmt == LAW_A_INV),
        .sample_in   (tx_sample),
        .code_in     (rx_code[COMP_W-1:0]),
        .code_out    (a_code),
        .sample_out  (a_smp)
    );

    // Pick the encode and decode results for the selected format.
    always_comb begin
        if (!code_mode) begin
            enc_nx = lin_code;
            dec_nx = lin_smp;
        end else if (cfmt == LAW_MU) begin
            enc_nx = {{PAD_W{1'b0}}, mu_code};
            dec_nx = mu_smp;
        end else begin
            enc_nx = {{PAD_W{1'b0}}, a_code};
            dec_nx = a_smp;
        end
    end

    // Output registers: load on strobe, flag one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            tx_code   <= '0;
            rx_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                tx_code   <= enc_nx;
                rx_sample <= dec_nx;
            end
        end
    end

endmodule

// File: rtl/pcm_code_converter_chk.sv
// Checker: timing and format properties of the converter's ports.
// Assumes it is bound to every instance of the top module.
module pcm_code_converter_chk
    import pcm_conv_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                code_mode,
    input logic [1:0]          code_sel,
    input logic [SAMPLE_W-1:0] tx_sample,
    input logic [SAMPLE_W-1:0] rx_code,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] tx_code,
    input logic [SAMPLE_W-1:0] rx_sample
);

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(tx_code) && $stable(rx_sample)));

    assert_twos_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !code_mode && code_sel == 2'b00)
        |=> (tx_code == $past(tx_sample) && rx_sample == $past(rx_code)));

    assert_comp_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code_mode) |=> (tx_code[SAMPLE_W-1:COMP_W] == '0));

    assert_mu_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code_mode && code_sel == 2'b00 && tx_sample == '0)
        |=> (tx_code == SAMPLE_W'(8'hFF)));

    assert_aplain_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code_mode && code_sel[1])
        |=> (tx_code[COMP_W-1] == !$past(tx_sample[SAMPLE_W-1])));

endmodule

bind pcm_code_converter pcm_code_converter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .code_mode (code_mode),
    .code_sel  (code_sel),
    .tx_sample (tx_sample),
    .rx_code   (rx_code),
    .out_valid (out_valid),
    .tx_code   (tx_code),
    .rx_sample (rx_sample)
);

// File: tb/tb_pcm_code_converter.sv
module tb_pcm_code_converter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        code_mode = 1'b0;
    logic [1:0]  code_sel = 2'b00;
    logic [13:0] tx_sample = '0;
    logic [13:0] rx_code = '0;
    logic        out_valid;
    logic [13:0] tx_code;
    logic [13:0] rx_sample;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model of the output stage
    logic [13:0] mdl_tx = '0, mdl_rx = '0;
    bit          pend = 0, pend_v = 0;
    string       pend_ttag = "", pend_rtag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_code_converter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .code_mode(code_mode),
        .code_sel(code_sel), .tx_sample(tx_sample), .rx_code(rx_code),
        .out_valid(out_valid), .tx_code(tx_code), .rx_sample(rx_sample)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int ref_enc(input bit m, input bit [1:0] s, input logic [13:0] v);
        int x = $signed(v);
        int mag, seg, code, a;
        if (!m) begin
            if (s == 0 || x >= 0) return int'(v);
            mag = (-x > 8191) ? 8191 : -x;
            if (s == 1) return 16383 - mag;
            return 8192 + mag;
        end
        if (s == 0) begin
            mag = (x < 0) ? -x : x;
            if (mag > 8159) mag = 8159;
            mag += 33;
            seg = 0;
            while (seg < 8 && mag >= (64 << seg)) seg++;
            code = (seg == 8) ? 127 : seg * 16 + ((mag >> (seg + 1)) % 16);
            return (x < 0) ? (code ^ 127) : (code ^ 255);
        end
        a = x >>> 1;
        mag = (a < 0) ? -a - 1 : a;
        seg = 0;
        while (seg < 7 && mag >= (32 << seg)) seg++;
        code = ((a >= 0) ? 128 : 0) + seg * 16 + ((mag >> ((seg < 2) ? 1 : seg)) % 16);
        return (s == 1) ? (code ^ 85) : code;
    endfunction

    function automatic int ref_dec(input bit m, input bit [1:0] s, input logic [13:0] v);
        int c, seg, mag, r;
        if (!m) begin
            if (s == 0 || v[13] == 1'b0) return int'(v);
            mag = (s == 1) ? (16383 - int'(v)) : (int'(v) - 8192);
            return (-mag) & 16383;
        end
        c = int'(v[7:0]);
        if (s == 0) begin
            c = 255 - c;
            seg = (c / 16) % 8;
            mag = ((c % 16) * 2 + 33) * (1 << seg) - 33;
            r = (c >= 128) ? -mag : mag;
        end else begin
            if (s == 1) c = c ^ 85;
            seg = (c / 16) % 8;
            mag = (seg == 0) ? (c % 16) * 4 + 2 : ((c % 16) * 4 + 66) * (1 << (seg - 1));
            r = (c >= 128) ? mag : -mag;
        end
        return r & 16383;
    endfunction

    function automatic string tag_tx(input bit m, input bit [1:0] s);
        if (!m) return (s == 0) ? "R4" : (s == 1) ? "R5" : "R6";
        return (s == 0) ? "R8" : (s == 1) ? "R11" : "R10";
    endfunction

    function automatic string tag_rx(input bit m, input bit [1:0] s);
        if (!m) return (s == 0) ? "R4" : (s == 1) ? "R5" : "R6";
        return (s == 0) ? "R9" : "R12";
    endfunction

    // Compare the outputs due from the previous drive.
    task automatic compare_pending();
        if (pend) begin
            chk(out_valid === pend_v, "R2", int'(out_valid), int'(pend_v));
            chk(tx_code === mdl_tx, pend_ttag, int'(tx_code), int'(mdl_tx));
            chk(rx_sample === mdl_rx, pend_rtag, int'(rx_sample), int'(mdl_rx));
        end
    endtask

    // One cycle: check last results, drive new inputs, advance the model.
    task automatic step(input bit m, input bit [1:0] s, input logic [13:0] tx,
                        input logic [13:0] rx, input bit v, input string tg);
        @(negedge clk);
        compare_pending();
        in_valid = v; code_mode = m; code_sel = s; tx_sample = tx; rx_code = rx;
        if (v) begin
            mdl_tx = 14'(ref_enc(m, s, tx));
            mdl_rx = 14'(ref_dec(m, s, rx));
        end
        pend = 1; pend_v = v;
        pend_ttag = (tg != "") ? tg : (v ? tag_tx(m, s) : "R3");
        pend_rtag = (tg != "") ? tg : (v ? tag_rx(m, s) : "R3");
    endtask

    task automatic flush();
        @(negedge clk);
        compare_pending();
        in_valid = 0;
        pend = 0;
    endtask

    // Fixed reference point checked against literal values.
    task automatic lit(input bit m, input bit [1:0] s, input logic [13:0] tx,
                       input logic [13:0] rx, input logic [13:0] etx,
                       input logic [13:0] erx, input string tg);
        step(m, s, tx, rx, 1, tg);
        flush();
        chk(tx_code === etx, tg, int'(tx_code), int'(etx));
        chk(rx_sample === erx, tg, int'(rx_sample), int'(erx));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates an active strobe
        rst_n = 0; in_valid = 1; code_mode = 1; tx_sample = 14'h1234; rx_code = 14'h0055;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
        chk(tx_code === 14'h0, "R1", int'(tx_code), 0);
        chk(rx_sample === 14'h0, "R1", int'(rx_sample), 0);
        rst_n = 1; in_valid = 0;

        // literal reference points
        lit(1, 2'd0, 14'h1FFF, 14'h3FFF, 14'h0080, 14'h0000, "R8");
        lit(1, 2'd0, 14'h0000, 14'h0080, 14'h00FF, 14'h1F5F, "R8");
        lit(1, 2'd0, 14'h2000, 14'h00FF, 14'h0000, 14'h0000, "R8");
        lit(1, 2'd1, 14'h1FFF, 14'h00D5, 14'h00AA, 14'h0002, "R11");
        lit(1, 2'd1, 14'h0000, 14'h00D5, 14'h00D5, 14'h0002, "R11");
        lit(1, 2'd1, 14'h2000, 14'h00D5, 14'h002A, 14'h0002, "R11");
        lit(1, 2'd2, 14'h1FFF, 14'h0080, 14'h00FF, 14'h0002, "R10");
        lit(1, 2'd2, 14'h0000, 14'h0080, 14'h0080, 14'h0002, "R10");
        lit(1, 2'd3, 14'h2000, 14'h0080, 14'h007F, 14'h0002, "R10");
        lit(0, 2'd1, 14'h2000, 14'h3FFF, 14'h2000, 14'h0000, "R5");
        lit(0, 2'd2, 14'h2000, 14'h2000, 14'h3FFF, 14'h0000, "R6");
        lit(1, 2'd0, 14'h0000, 14'h3FFF, 14'h00FF, 14'h0000, "R7");

        // full sweeps of every format
        for (int mm = 0; mm < 2; mm++)
            for (int ss = 0; ss < 3; ss++)
                for (int i = 0; i < 16384; i++)
                    step(mm[0], 2'(ss), 14'(i), 14'(i ^ 16'h1555), 1, "");
        // select value 11 aliases to 10
        for (int mm = 0; mm < 2; mm++)
            for (int i = 0; i < 1024; i++)
                step(mm[0], 2'd3, 14'(i * 16 + 7), 14'(i * 13), 1, "");

        // R3: idle cycles with changing inputs
        for (int i = 0; i < 20; i++)
            step(i[0], 2'(i), 14'(i * 811), 14'(i * 977), 0, "");

        // R13: format changes every cycle
        for (int i = 0; i < 60; i++)
            step(i[0], 2'(i % 3), 14'(i * 271 + 5), 14'(i * 97), 1, "R13");
        flush();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule